// File: doc/BRIEF.md
# Inclusive Two-Level Cache Tag Directory

This block keeps only the tags of a two-level set-associative cache hierarchy and stores no data. A requester presents a line address, which is the physical address with the 6-bit byte offset removed. The block reports whether the line was present in the small first level and in the larger second level. On a miss it installs the line, and it chooses a victim by least-recently-used order.

The two levels are kept strictly inclusive. When the second level evicts a line, any first-level copy of that line is dropped in the same cycle. A flush command removes one line from both levels. Each response carries a latency code, and the response strobe appears exactly that many cycles after the request was accepted. This makes the difference between fast and slow accesses visible at the ports, so the block can serve as a timing model of the hierarchy.

Top module: `inclusive_tag_dir`

## Requirements
- R1: After reset, `ready_o` is 1 and `rsp_valid_o` is 0, and both levels are empty, so the first lookup of any line misses in both levels.
- R2: A lookup of a line present in level 1 responds with `rsp_l1_hit_o`=1, `rsp_l2_hit_o`=1 and latency code 1.
- R3: A lookup that misses level 1 but hits level 2 responds with latency code 4 and installs the line in level 1, so an immediate repeat hits level 1.
- R4: A lookup that misses both levels responds with latency code 20 and installs the line in both levels.
- R5: A request is accepted on a rising edge where `req_valid_i` and `ready_o` are both 1. `ready_o` is then 0 until `rsp_valid_o` rises, and `rsp_valid_o` is 1 for one cycle, exactly latency-code cycles after the accepting edge.
- R6: With `req_line_i` equal to address bits 31:6, the level-1 set is `req_line_i[5:0]` and the level-2 set is `req_line_i[8:0]`. A line is only ever held in its own set.
- R7: A fill into a full set replaces the least recently used line of that set. Level 1 has 8 ways per set and level 2 has 4.
- R8: Every hit and every fill makes the touched line the most recently used in its set. A level-1 hit does not change level-2 recency.
- R9: Any line present in level 1 is present in level 2. When level 2 evicts a line, the level-1 copy of that line is invalidated in the same operation.
- R10: A flush (`req_op_i`=1; 0 is lookup) responds with latency code 1, and its hit flags report where the line was present. After the flush the line is absent from both levels.
- R11: A flush of a line that is absent changes no replacement order.
- R12: `req_valid_i` while `ready_o` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 1 | 0 lookup, 1 flush |
| req_line_i | input | 26 | Line address (address bits 31:6) |
| ready_o | output | 1 | Idle, a request can be accepted |
| rsp_valid_o | output | 1 | Response strobe, one cycle |
| rsp_flush_o | output | 1 | Response belongs to a flush |
| rsp_l1_hit_o | output | 1 | Line was in level 1 before the operation |
| rsp_l2_hit_o | output | 1 | Line was in level 2 before the operation |
| rsp_lat_o | output | 5 | Latency code: 1, 4 or 20 |

## Verification
A directed sequence drives lines that share level-1 set 0 but spread across several level-2 sets. This separates level-1 capacity eviction, where a line stays in level 2 and a lookup returns code 4, from level-2 eviction with back-invalidation, where a lookup returns code 20. Flushes of lines held in both levels, in level 2 only and in neither are each followed by a further miss. That miss shows whether the flush removed the line and whether it left the LRU order intact. A random phase over a small pool of conflicting lines, with flushes mixed in, compares every response and every cycle of strobe timing against a queue-based recency model.

// File: rtl/cdir_pkg.sv
package cdir_pkg;
  typedef enum logic {
    OP_LOOKUP = 1'b0,
    OP_FLUSH  = 1'b1
  } cdir_op_e;
endpackage

// File: rtl/cdir_match.sv
module cdir_match #(
  parameter int WAYS  = 8,
  parameter int TAG_W = 20
) (
  input  logic [WAYS*TAG_W-1:0]     tags_i,
  input  logic [WAYS-1:0]           valid_i,
  input  logic [TAG_W-1:0]          tag_i,
  output logic                      hit_o,
  output logic [$clog2(WAYS)-1:0]   way_o
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = valid_i[w] && (tags_i[w*TAG_W +: TAG_W] == tag_i);
  end

  always_comb begin
    hit_o = 1'b0;
    way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (eq[w] && !hit_o) begin
        hit_o = 1'b1;
        way_o = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/cdir_level.sv
module cdir_level #(
  parameter int SETS  = 64,
  parameter int WAYS  = 8,
  parameter int TAG_W = 20
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [$clog2(SETS)-1:0]   set_i,
  input  logic                      wr_en_i,
  input  logic [$clog2(WAYS)-1:0]   wr_way_i,
  input  logic                      wr_valid_i,
  input  logic                      wr_touch_i,
  input  logic [TAG_W-1:0]          wr_tag_i,
  output logic [WAYS*TAG_W-1:0]     tags_o,
  output logic [WAYS-1:0]           valid_o,
  output logic [$clog2(WAYS)-1:0]   victim_o
);
  localparam int WAY_W = $clog2(WAYS);

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAY_W-1:0] age_q [SETS][WAYS];  // 0 = MRU, WAYS-1 = LRU

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[set_i][wr_way_i] <= wr_tag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
    end else if (wr_en_i) begin
      vld_q[set_i][wr_way_i] <= wr_valid_i;
      if (wr_touch_i) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == wr_way_i)
            age_q[set_i][w] <= '0;
          else if (age_q[set_i][w] < age_q[set_i][wr_way_i])
            age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
        end
      end
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_out
    assign tags_o[w*TAG_W +: TAG_W] = tag_q[set_i][w];
  end
  assign valid_o = vld_q[set_i];

  // free way first, else the oldest
  always_comb begin
    logic found;
    found    = 1'b0;
    victim_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !vld_q[set_i][w]) begin
        found    = 1'b1;
        victim_o = WAY_W'(w);
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_q[set_i][w] == WAY_W'(WAYS - 1)) victim_o = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/cdir_timer.sv
module cdir_timer #(
  parameter int LAT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [LAT_W-1:0] cnt_q;
  logic             busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= lat_i;
      end else if (busy_q) begin
        if (cnt_q == LAT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/inclusive_tag_dir.sv
module inclusive_tag_dir #(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 6,
  parameter int L1_SETS   = 64,
  parameter int L1_WAYS   = 8,
  parameter int L2_SETS   = 512,
  parameter int L2_WAYS   = 4,
  parameter int LAT_L1    = 1,
  parameter int LAT_L2    = 4,
  parameter int LAT_MISS  = 20,
  parameter int LAT_FLUSH = 1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              req_valid_i,
  input  logic                              req_op_i,
  input  logic [ADDR_W-OFF_W-1:0]           req_line_i,
  output logic                              ready_o,
  output logic                              rsp_valid_o,
  output logic                              rsp_flush_o,
  output logic                              rsp_l1_hit_o,
  output logic                              rsp_l2_hit_o,
  output logic [$clog2(LAT_MISS+1)-1:0]     rsp_lat_o
);
  import cdir_pkg::*;

  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int L1_IW  = $clog2(L1_SETS);
  localparam int L2_IW  = $clog2(L2_SETS);
  localparam int L1_TW  = LINE_W - L1_IW;
  localparam int L2_TW  = LINE_W - L2_IW;
  localparam int L1_WW  = $clog2(L1_WAYS);
  localparam int L2_WW  = $clog2(L2_WAYS);
  localparam int LAT_W  = $clog2(LAT_MISS + 1);

  logic [L1_IW-1:0] l1_set;
  logic [L2_IW-1:0] l2_set;
  logic [L1_TW-1:0] l1_tag;
  logic [L2_TW-1:0] l2_tag;
  assign l1_set = req_line_i[L1_IW-1:0];
  assign l2_set = req_line_i[L2_IW-1:0];
  assign l1_tag = req_line_i[LINE_W-1:L1_IW];
  assign l2_tag = req_line_i[LINE_W-1:L2_IW];

  logic                     busy, accept, is_flush;
  logic [L1_WAYS*L1_TW-1:0] l1_tags;
  logic [L2_WAYS*L2_TW-1:0] l2_tags;
  logic [L1_WAYS-1:0]       l1_vld;
  logic [L2_WAYS-1:0]       l2_vld;
  logic [L1_WW-1:0]         l1_vic, l1_hway, bi_way, l1_wway;
  logic [L2_WW-1:0]         l2_vic, l2_hway, l2_wway;
  logic                     l1_hit, l2_hit, bi_hit;
  logic                     l1_we, l1_wv, l1_touch, l2_we, l2_wv, l2_touch;
  logic [LAT_W-1:0]         lat_d;

  assign accept   = req_valid_i && !busy;
  assign is_flush = (cdir_op_e'(req_op_i) == OP_FLUSH);

  cdir_level #(.SETS(L1_SETS), .WAYS(L1_WAYS), .TAG_W(L1_TW)) u_l1 (
    .clk_i, .rst_ni, .set_i(l1_set), .wr_en_i(l1_we), .wr_way_i(l1_wway),
    .wr_valid_i(l1_wv), .wr_touch_i(l1_touch), .wr_tag_i(l1_tag),
    .tags_o(l1_tags), .valid_o(l1_vld), .victim_o(l1_vic)
  );

  cdir_level #(.SETS(L2_SETS), .WAYS(L2_WAYS), .TAG_W(L2_TW)) u_l2 (
    .clk_i, .rst_ni, .set_i(l2_set), .wr_en_i(l2_we), .wr_way_i(l2_wway),
    .wr_valid_i(l2_wv), .wr_touch_i(l2_touch), .wr_tag_i(l2_tag),
    .tags_o(l2_tags), .valid_o(l2_vld), .victim_o(l2_vic)
  );

  cdir_match #(.WAYS(L1_WAYS), .TAG_W(L1_TW)) u_l1_hit (
    .tags_i(l1_tags), .valid_i(l1_vld), .tag_i(l1_tag), .hit_o(l1_hit), .way_o(l1_hway)
  );

  cdir_match #(.WAYS(L2_WAYS), .TAG_W(L2_TW)) u_l2_hit (
    .tags_i(l2_tags), .valid_i(l2_vld), .tag_i(l2_tag), .hit_o(l2_hit), .way_o(l2_hway)
  );

  // the L2 victim shares the L2 set, hence also the L1 set of the request
  logic [LINE_W-1:0] vic_line;
  logic              vic_vld;
  assign vic_line = {l2_tags[l2_vic*L2_TW +: L2_TW], l2_set};
  assign vic_vld  = l2_vld[l2_vic];

  cdir_match #(.WAYS(L1_WAYS), .TAG_W(L1_TW)) u_bi_probe (
    .tags_i(l1_tags), .valid_i(l1_vld), .tag_i(vic_line[LINE_W-1:L1_IW]),
    .hit_o(bi_hit), .way_o(bi_way)
  );

  always_comb begin
    l1_we = 1'b0; l1_wv = 1'b1; l1_touch = 1'b1; l1_wway = l1_hway;
    l2_we = 1'b0; l2_wv = 1'b1; l2_touch = 1'b1; l2_wway = l2_hway;
    lat_d = LAT_W'(LAT_MISS);
    if (is_flush) begin
      l1_we = l1_hit; l1_wv = 1'b0; l1_touch = 1'b0;
      l2_we = l2_hit; l2_wv = 1'b0; l2_touch = 1'b0;
      lat_d = LAT_W'(LAT_FLUSH);
    end else if (l1_hit) begin
      l1_we = 1'b1;
      lat_d = LAT_W'(LAT_L1);
    end else if (l2_hit) begin
      l2_we   = 1'b1;
      l1_we   = 1'b1;
      l1_wway = l1_vic;
      lat_d   = LAT_W'(LAT_L2);
    end else begin
      l2_we   = 1'b1;
      l2_wway = l2_vic;
      l1_we   = 1'b1;
      // back-invalidated way is reused by the fill in the same write
      l1_wway = (vic_vld && bi_hit) ? bi_way : l1_vic;
    end
    l1_we = l1_we && accept;
    l2_we = l2_we && accept;
  end

  logic             flush_q, l1h_q, l2h_q;
  logic [LAT_W-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_q <= 1'b0;
      l1h_q   <= 1'b0;
      l2h_q   <= 1'b0;
      lat_q   <= '0;
    end else if (accept) begin
      flush_q <= is_flush;
      l1h_q   <= l1_hit;
      l2h_q   <= l2_hit;
      lat_q   <= lat_d;
    end
  end

  cdir_timer #(.LAT_W(LAT_W)) u_timer (
    .clk_i, .rst_ni, .start_i(accept), .lat_i(lat_d), .busy_o(busy), .done_o(rsp_valid_o)
  );

  assign ready_o      = !busy;
  assign rsp_flush_o  = flush_q;
  assign rsp_l1_hit_o = l1h_q;
  assign rsp_l2_hit_o = l2h_q;
  assign rsp_lat_o    = lat_q;
endmodule

// File: rtl/cdir_checker.sv
module cdir_checker #(
  parameter int LAT_W    = 5,
  parameter int LAT_L1   = 1,
  parameter int LAT_L2   = 4,
  parameter int LAT_MISS = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             ready_o,
  input logic             rsp_valid_o,
  input logic             rsp_flush_o,
  input logic             rsp_l1_hit_o,
  input logic             rsp_l2_hit_o,
  input logic [LAT_W-1:0] rsp_lat_o
);
  logic [LAT_W-1:0] elapsed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     elapsed_q <= '0;
    else if (req_valid_i && ready_o) elapsed_q <= '0;
    else if (!ready_o)               elapsed_q <= elapsed_q + 1'b1;
  end

  assert_rsp_when_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ready_o);

  assert_busy_after_accept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ready_o) |=> !ready_o);

  assert_latency_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (elapsed_q == rsp_lat_o));

  assert_inclusion_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_l1_hit_o) |-> rsp_l2_hit_o);

  assert_l1_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_flush_o && rsp_l1_hit_o) |-> (rsp_lat_o == LAT_W'(LAT_L1)));

  assert_l2_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_flush_o && !rsp_l1_hit_o && rsp_l2_hit_o) |-> (rsp_lat_o == LAT_W'(LAT_L2)));

  assert_miss_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_flush_o && !rsp_l2_hit_o) |-> (rsp_lat_o == LAT_W'(LAT_MISS)));
endmodule

bind inclusive_tag_dir cdir_checker chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .ready_o(ready_o),
  .rsp_valid_o(rsp_valid_o), .rsp_flush_o(rsp_flush_o), .rsp_l1_hit_o(rsp_l1_hit_o),
  .rsp_l2_hit_o(rsp_l2_hit_o), .rsp_lat_o(rsp_lat_o)
);

// File: tb/inclusive_tag_dir_tb_top.sv
module inclusive_tag_dir_tb_top;
  localparam int S1 = 64, W1 = 8, S2 = 512, W2 = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_op = 1'b0;
  logic [25:0] req_line = '0;
  logic        ready, rsp_valid, rsp_flush, rsp_l1, rsp_l2;
  logic [4:0]  rsp_lat;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  inclusive_tag_dir dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_line_i(req_line), .ready_o(ready), .rsp_valid_o(rsp_valid),
    .rsp_flush_o(rsp_flush), .rsp_l1_hit_o(rsp_l1), .rsp_l2_hit_o(rsp_l2), .rsp_lat_o(rsp_lat)
  );

  // recency queues, front = most recent
  int unsigned q1 [S1][$];
  int unsigned q2 [S2][$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int find1(int s, int unsigned ln);
    for (int i = 0; i < q1[s].size(); i++) if (q1[s][i] == ln) return i;
    return -1;
  endfunction

  function automatic int find2(int s, int unsigned ln);
    for (int i = 0; i < q2[s].size(); i++) if (q2[s][i] == ln) return i;
    return -1;
  endfunction

  task automatic model_op(input bit fl, input int unsigned ln, output bit h1, output bit h2, output int lat);
    int s1, s2, i1, i2, iv;
    int unsigned v;
    s1 = int'(ln % S1);
    s2 = int'(ln % S2);
    i1 = find1(s1, ln);
    i2 = find2(s2, ln);
    h1 = (i1 >= 0);
    h2 = (i2 >= 0);
    if (fl) begin
      if (h1) q1[s1].delete(i1);
      if (h2) q2[s2].delete(i2);
      lat = 1;
    end else if (h1) begin
      q1[s1].delete(i1);
      q1[s1].push_front(ln);
      lat = 1;
    end else if (h2) begin
      q2[s2].delete(i2);
      q2[s2].push_front(ln);
      if (q1[s1].size() == W1) v = q1[s1].pop_back();
      q1[s1].push_front(ln);
      lat = 4;
    end else begin
      if (q2[s2].size() == W2) begin
        v  = q2[s2].pop_back();
        iv = find1(s1, v);
        if (iv >= 0) q1[s1].delete(iv);
      end
      q2[s2].push_front(ln);
      if (q1[s1].size() == W1) v = q1[s1].pop_back();
      q1[s1].push_front(ln);
      lat = 20;
    end
  endtask

  // drive at a negedge with ready high; hand < 0 skips the hand-computed code check
  task automatic do_req(input bit fl, input int unsigned ln, input bit noise, input string req, input int hand);
    bit h1, h2;
    int lat;
    while (!ready) @(negedge clk);
    req_valid = 1'b1;
    req_op    = fl;
    req_line  = 26'(ln);
    model_op(fl, ln, h1, h2, lat);
    @(negedge clk);
    if (noise) begin
      req_op = 1'b1;  // flush of the same line while busy must be dropped (R12)
    end else begin
      req_valid = 1'b0;
    end
    for (int j = 0; j <= lat; j++) begin
      if (j > 0) @(negedge clk);
      chk(rsp_valid == (j == lat), "R5", $sformatf("rsp_valid at cycle %0d", j), rsp_valid, j == lat);
      chk(ready == (j == lat), "R5", $sformatf("ready at cycle %0d", j), ready, j == lat);
    end
    req_valid = 1'b0;
    chk(rsp_lat == 5'(lat), req, "latency code", rsp_lat, lat);
    chk(rsp_l1 == h1, req, "l1 hit flag", rsp_l1, h1);
    chk(rsp_l2 == h2, req, "l2 hit flag", rsp_l2, h2);
    chk(rsp_flush == fl, req, "flush flag", rsp_flush, fl);
    if (hand >= 0) chk(rsp_lat == 5'(hand), req, "directed latency", rsp_lat, hand);
  endtask

  function automatic int unsigned la(int k); return k * 512;       endfunction
  function automatic int unsigned lb(int k); return k * 512 + 64;  endfunction
  function automatic int unsigned lc(int k); return k * 512 + 128; endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R1", "ready in reset", ready, 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R1", "ready after reset", ready, 1);

    do_req(0, la(0), 1, "R1", 20);        // empty directory; R4 fill
    do_req(0, la(0), 0, "R12", 1);       // ignored flush left it in place; R2
    do_req(0, la(1), 0, "R4", 20);
    do_req(0, la(2), 0, "R4", 20);
    do_req(0, la(3), 0, "R4", 20);
    do_req(0, la(0), 0, "R8", 1);        // L1 hit does not refresh L2
    do_req(0, la(4), 0, "R9", 20);       // L2 evicts la0, back-invalidated
    do_req(0, la(0), 0, "R9", 20);
    for (int k = 0; k < 4; k++) do_req(0, lb(k), 0, "R6", 20);
    do_req(0, lc(0), 0, "R7", 20);       // L1 set full, la2 pushed out of L1
    do_req(0, la(2), 0, "R3", 4);
    do_req(0, la(2), 0, "R3", 1);
    do_req(0, la(3), 0, "R3", 4);
    do_req(0, la(5), 0, "R7", 20);       // L2 evicts la4 only
    do_req(0, la(0), 0, "R7", 4);
    do_req(0, la(4), 0, "R7", 20);
    do_req(1, la(3), 0, "R10", 1);
    do_req(0, la(3), 0, "R10", 20);
    do_req(1, lb(0), 0, "R10", 1);       // present in L2 only
    do_req(0, lb(0), 0, "R10", 20);
    do_req(1, la(9), 0, "R11", 1);       // absent
    do_req(0, la(6), 0, "R11", 20);
    do_req(0, la(5), 0, "R11", 20);      // la5 was LRU and still got evicted
    do_req(0, 1, 0, "R6", 20);
    do_req(0, 1, 0, "R6", 1);
    do_req(0, la(6), 0, "R6", 1);

    for (int n = 0; n < 400; n++) begin
      int unsigned s, t;
      bit fl;
      t  = $urandom_range(0, 5);
      s  = $urandom_range(0, 3);
      s  = (s == 3) ? 1 : s * 64;
      fl = ($urandom_range(0, 99) < 15);
      do_req(fl, t * 512 + s, ($urandom_range(0, 9) == 0) ? 1'b1 : 1'b0, fl ? "R10" : "R7", -1);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule